// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block moves received Ethernet frames from a byte stream into host memory. The host keeps a ring of receive descriptors in shared memory. Each descriptor is four 16-bit words and points at one buffer. A descriptor may be written by the engine only while its ownership bit is set. For each frame the engine claims the next owned descriptor and packs the bytes into that buffer. If the frame needs more room, it moves on to further owned descriptors. It then writes the frame length and the status flags, and hands every descriptor it used back to the host by clearing the ownership bit.

The stream carries start and end markers. It also carries two sideband error indications, for CRC and framing errors, which are valid with the last byte. The block stalls the stream with `in_ready` while it reads descriptors or writes status. A single 16-bit memory port with byte enables does all descriptor reads and all data and status writes. A read request returns its data on the next cycle. The ring base address and the log2 of the ring size are static inputs.

The block raises a one-cycle `rx_done` pulse for each frame whose final descriptor has been handed back. It raises a one-cycle `missed` pulse for each frame it could not start because the host still owned the next descriptor.

Top module: `rx_ring_writer`

## Requirements
- R1: Descriptor i sits at byte address ring_base + 8*i. Word +0 is the buffer address bits 15:0. Word +2 holds the flag byte in bits 15:8 and buffer address bits 23:16 in bits 7:0. Word +4 is the buffer size. Word +6 is the message length. The engine starts to use a descriptor only when flag bit 7 (ownership, 1 = engine) reads as 1.
- R2: Frame bytes are stored from the buffer address upward, two per 16-bit word. The byte at the even address goes in bits 7:0 and the byte at the odd address in bits 15:8. A frame that ends on an even offset writes its last byte with only the low byte enable, so bits 15:8 of that word are left unchanged.
- R3: The buffer size is read from word +4 as the two's complement negative of the byte count, in bits 11:0 (bits 15:12 are set by the host). No data byte is ever written at or beyond buffer address + size.
- R4: A frame longer than one buffer continues into the following descriptors. A descriptor that is closed before the end of the frame gets flag 0x02 (start of packet) if it is the first one of the frame, and 0x00 otherwise.
- R5: The last descriptor of a frame gets the end-of-packet bit (bit 0), plus bit 1 if it is also the first. Its word +6 receives the total frame length in bytes, including the 4-byte check sequence, in bits 11:0. Word +6 of descriptors that are not last is not written.
- R6: A CRC error seen with the end byte sets bit 3, and a framing error sets bit 5. Either one also sets the error summary bit 6. These bits are reported only on the last descriptor.
- R7: For each descriptor, the flag byte write is the final memory write, and it has ownership bit 7 clear. `rx_done` pulses for exactly one cycle, in the cycle after the final flag write of each frame.
- R8: If the descriptor at the current index is not owned when a frame starts, the whole frame is consumed without any memory write and `missed` pulses for one cycle. The ring index does not move.
- R9: If a frame must chain while the next descriptor is not owned, the current descriptor is closed with buffer error (bit 2), overflow (bit 4) and error summary (bit 6) set, plus start of packet if it was the first, and without end of packet. The rest of the frame is discarded, `rx_done` pulses, and the ring index moves to that next descriptor.
- R10: The ring index advances modulo 2^ring_log2, so the descriptor after index 2^ring_log2 - 1 is index 0.
- R11: Stream bytes that arrive outside a frame, without a start marker, are accepted and discarded with no memory write and no pulse.
- R12: After reset the ring index is 0, both pulses are low, no memory request is made, and `in_ready` is high while no start marker is offered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base | input | AW | Byte address of descriptor 0 |
| ring_log2 | input | 3 | Log2 of the number of descriptors |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_sop | input | 1 | First byte of a frame |
| in_eop | input | 1 | Last byte of a frame |
| in_crc_err | input | 1 | CRC error, sampled with the end byte |
| in_frame_err | input | 1 | Framing error, sampled with the end byte |
| in_ready | output | 1 | Byte taken when high together with in_valid |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_be | output | 2 | Byte enables, bit 0 for bits 7:0 |
| mem_addr | output | AW | Even byte address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read request |
| rx_done | output | 1 | Frame handed back pulse |
| missed | output | 1 | Frame dropped for lack of a descriptor pulse |

## Verification
The bench uses the default parameters (24-bit addresses, index width 7) and drives `ring_log2` to 2. With only four descriptors, a few frames are enough to reach the wrap from index 3 to index 0. Buffers of 8 bytes force a 20-byte frame across three descriptors. A non-owned neighbour then turns chaining into the overflow path, and afterwards into a missed frame at the same index. Odd and even frame lengths, and each error sideband, are checked against memory contents that the bench computes on its own.

// File: rtl/rx_ring_writer.sv
module rx_ring_writer #(
  parameter int AW = 24,
  parameter int IW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ring_base,
  input  logic [2:0]    ring_log2,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_sop,
  input  logic          in_eop,
  input  logic          in_crc_err,
  input  logic          in_frame_err,
  output logic          in_ready,
  output logic          mem_req,
  output logic          mem_we,
  output logic [1:0]    mem_be,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  input  logic [15:0]   mem_rdata,
  output logic          rx_done,
  output logic          missed
);
  localparam int LW = 12;
  localparam logic [1:0] K_END = 2'd0, K_CHAIN = 2'd1, K_OVF = 2'd2;

  typedef enum logic [3:0] {
    S_IDLE, S_RDF, S_CKF, S_RDA, S_GETA, S_GETS, S_DATA, S_WLEN, S_WFLG, S_DROP
  } st_t;

  st_t st;
  logic [IW-1:0] idx, rd_idx, mask, nxt;
  logic [AW-1:0] buf_addr;
  logic [LW-1:0] size, cnt, flen;
  logic [7:0]    lo, flag;
  logic          first, chain, crc_q, fram_q;
  logic [1:0]    kind;

  assign mask = IW'((32'd1 << ring_log2) - 32'd1);
  assign nxt  = (idx + 1'b1) & mask;

  wire own  = mem_rdata[15];
  wire full = (cnt == size);
  assign in_ready = (st == S_DATA && !full) || st == S_DROP || (st == S_IDLE && !in_sop);
  wire take = in_valid && in_ready;

  function automatic logic [AW-1:0] daddr(input logic [IW-1:0] i, input logic [2:0] off);
    daddr = ring_base + AW'({i, 3'b000}) + AW'(off);
  endfunction

  always_comb
    case (kind)
      K_END:   flag = {1'b0, crc_q | fram_q, fram_q, 1'b0, crc_q, 1'b0, first, 1'b1};
      K_CHAIN: flag = {6'b0, first, 1'b0};
      default: flag = {1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, first, 1'b0};
    endcase

  always_comb begin
    mem_req = 1'b0; mem_we = 1'b0; mem_be = 2'b11; mem_addr = '0; mem_wdata = '0;
    case (st)
      S_RDF:  begin mem_req = 1'b1; mem_addr = daddr(rd_idx, 3'd2); end
      S_RDA:  begin mem_req = 1'b1; mem_addr = daddr(idx, 3'd0); end
      S_GETA: begin mem_req = 1'b1; mem_addr = daddr(idx, 3'd4); end
      S_DATA: if (take && (cnt[0] || in_eop)) begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_addr  = buf_addr + AW'({cnt[LW-1:1], 1'b0});
        mem_be    = cnt[0] ? 2'b11 : 2'b01;
        mem_wdata = cnt[0] ? {in_data, lo} : {8'h00, in_data};
      end
      S_WLEN: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = daddr(idx, 3'd6); mem_wdata = {4'h0, flen}; end
      S_WFLG: begin mem_req = 1'b1; mem_we = 1'b1; mem_be = 2'b10; mem_addr = daddr(idx, 3'd2); mem_wdata = {flag, 8'h00}; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; idx <= '0; rd_idx <= '0; buf_addr <= '0; size <= '0; cnt <= '0;
      flen <= '0; lo <= '0; first <= 1'b0; chain <= 1'b0; crc_q <= 1'b0; fram_q <= 1'b0;
      kind <= K_END; rx_done <= 1'b0; missed <= 1'b0;
    end else begin
      rx_done <= 1'b0;
      missed  <= 1'b0;
      case (st)
        S_IDLE: if (in_valid && in_sop) begin
          rd_idx <= idx; chain <= 1'b0; first <= 1'b1; flen <= '0; st <= S_RDF;
        end
        S_RDF: st <= S_CKF;
        S_CKF: begin
          if (own) buf_addr <= AW'({mem_rdata[7:0], 16'h0000});
          if (!chain) begin
            if (own) st <= S_RDA;
            else begin missed <= 1'b1; st <= S_DROP; end
          end else begin
            kind <= own ? K_CHAIN : K_OVF;
            st   <= S_WFLG;
          end
        end
        S_RDA: st <= S_GETA;
        S_GETA: begin buf_addr[15:0] <= mem_rdata; st <= S_GETS; end
        S_GETS: begin size <= ~mem_rdata[LW-1:0] + 1'b1; cnt <= '0; st <= S_DATA; end
        S_DATA:
          if (take) begin
            cnt  <= cnt + 1'b1;
            flen <= flen + 1'b1;
            if (!cnt[0]) lo <= in_data;
            if (in_eop) begin
              crc_q <= in_crc_err; fram_q <= in_frame_err; kind <= K_END; st <= S_WLEN;
            end
          end else if (in_valid && full) begin
            rd_idx <= nxt; chain <= 1'b1; st <= S_RDF;
          end
        S_WLEN: st <= S_WFLG;
        S_WFLG:
          case (kind)
            K_END:   begin idx <= nxt; rx_done <= 1'b1; st <= S_IDLE; end
            K_CHAIN: begin idx <= rd_idx; first <= 1'b0; chain <= 1'b0; st <= S_RDA; end
            default: begin idx <= rd_idx; rx_done <= 1'b1; st <= S_DROP; end
          endcase
        S_DROP: if (take && in_eop) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_fill_in_buffer_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DATA && mem_req) |-> ((mem_addr - buf_addr) < AW'(size)));

  assert_flag_write_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> $past(mem_req && mem_we && mem_be == 2'b10 && !mem_wdata[15]));

  assert_missed_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    missed |-> !$past(mem_req && mem_we));

  assert_index_in_ring_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (idx <= mask) && (rd_idx <= mask));

  assert_no_read_on_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !(mem_req && !mem_we));
endmodule

// File: tb/rx_ring_writer_test.sv
module rx_ring_writer_test;
  localparam int CLK_PERIOD = 10;
  localparam int RB = 'h100;

  logic clk = 0, rst_n = 0;
  logic [23:0] ring_base = 24'(RB);
  logic [2:0]  ring_log2 = 3'd2;
  logic in_valid = 0, in_sop = 0, in_eop = 0, in_crc_err = 0, in_frame_err = 0;
  logic [7:0] in_data = 0;
  logic in_ready, mem_req, mem_we, rx_done, missed;
  logic [1:0] mem_be;
  logic [23:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic [15:0] mem [0:4095];

  int tests = 0, fails = 0, n_done = 0, n_miss = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_ring_writer uut (
    .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .ring_log2(ring_log2),
    .in_valid(in_valid), .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop),
    .in_crc_err(in_crc_err), .in_frame_err(in_frame_err), .in_ready(in_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_be(mem_be), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rx_done(rx_done), .missed(missed));

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        if (mem_be[0]) mem[mem_addr[12:1]][7:0]  <= mem_wdata[7:0];
        if (mem_be[1]) mem[mem_addr[12:1]][15:8] <= mem_wdata[15:8];
      end else mem_rdata <= mem[mem_addr[12:1]];
    end
    if (rx_done) n_done++;
    if (missed) n_miss++;
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] dw(input int i, input int off);
    return mem[((RB + 8*i + off) >> 1) & 4095];
  endfunction

  function automatic logic [7:0] gb(input int a);
    return a[0] ? mem[(a >> 1) & 4095][15:8] : mem[(a >> 1) & 4095][7:0];
  endfunction

  task automatic setdesc(input int i, input bit own, input int b, input int sz);
    mem[(RB + 8*i) >> 1]     = b[15:0];
    mem[(RB + 8*i + 2) >> 1] = {own ? 8'h80 : 8'h00, b[23:16]};
    mem[(RB + 8*i + 4) >> 1] = 16'hF000 | {4'h0, 12'(-sz)};
    mem[(RB + 8*i + 6) >> 1] = 16'h0000;
  endtask

  task automatic fill(input int b, input int nwords, input logic [15:0] v);
    for (int k = 0; k < nwords; k++) mem[((b >> 1) + k) & 4095] = v;
  endtask

  task automatic push(input logic [7:0] d, input bit s, input bit e, input bit c, input bit f);
    @(negedge clk);
    in_valid = 1; in_data = d; in_sop = s; in_eop = e; in_crc_err = c; in_frame_err = f;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk);
  endtask

  task automatic idle_wait;
    @(negedge clk);
    in_valid = 0; in_sop = 0; in_eop = 0; in_crc_err = 0; in_frame_err = 0;
    repeat (10) @(negedge clk);
  endtask

  task automatic send(input int n, input int seed, input bit c, input bit f);
    for (int k = 0; k < n; k++)
      push(8'(seed + k), k == 0, k == n - 1, c && (k == n - 1), f && (k == n - 1));
    idle_wait();
  endtask

  task automatic t_reset;
    @(negedge clk); #1;
    chk("R12 in_ready", int'(in_ready), 1);
    chk("R12 rx_done", int'(rx_done), 0);
    chk("R12 missed", int'(missed), 0);
    chk("R12 mem_req", int'(mem_req), 0);
  endtask

  task automatic t_single;
    int d0, e;
    setdesc(0, 1, 'h1000, 64);
    d0 = n_done; e = 0;
    send(10, 'h10, 0, 0);
    for (int k = 0; k < 10; k++) if (gb('h1000 + k) != 8'(8'h10 + k)) e++;
    chk("R2 data bytes", e, 0);
    chk("R1 descriptor 0 used first, flag", int'(dw(0, 2)), 'h0300);
    chk("R5 length incl FCS", int'(dw(0, 6)), 10);
    chk("R3 size word untouched", int'(dw(0, 4)), 'hFFC0);
    chk("R7 one rx_done", n_done - d0, 1);
  endtask

  task automatic t_odd_crc;
    setdesc(1, 1, 'h1100, 64);
    fill('h1100, 8, 16'hAAAA);
    send(7, 'h20, 1, 0);
    chk("R2 odd tail low byte", int'(gb('h1106)), 'h26);
    chk("R2 odd tail high byte kept", int'(gb('h1107)), 'hAA);
    chk("R6 crc flags", int'(dw(1, 2)), 'h4B00);
    chk("R5 length 7", int'(dw(1, 6)), 7);
  endtask

  task automatic t_frame_err;
    setdesc(2, 1, 'h1200, 64);
    send(5, 'h30, 0, 1);
    chk("R6 framing flags", int'(dw(2, 2)), 'h6300);
  endtask

  task automatic t_chain;
    int e, d0;
    setdesc(3, 1, 'h1300, 8);
    setdesc(0, 1, 'h1000, 8);
    setdesc(1, 1, 'h1100, 8);
    fill('h1100, 8, 16'hAAAA);
    d0 = n_done; e = 0;
    send(20, 'h40, 0, 0);
    for (int k = 0; k < 8; k++) if (gb('h1300 + k) != 8'(8'h40 + k)) e++;
    for (int k = 0; k < 8; k++) if (gb('h1000 + k) != 8'(8'h48 + k)) e++;
    for (int k = 0; k < 4; k++) if (gb('h1100 + k) != 8'(8'h50 + k)) e++;
    chk("R3 R4 chained data", e, 0);
    chk("R3 no byte past buffer", int'(gb('h1104)), 'hAA);
    chk("R4 first flag", int'(dw(3, 2)), 'h0200);
    chk("R4 R10 middle flag after wrap", int'(dw(0, 2)), 'h0000);
    chk("R5 last flag", int'(dw(1, 2)), 'h0100);
    chk("R5 length 20 on last", int'(dw(1, 6)), 20);
    chk("R5 no length on first", int'(dw(3, 6)), 0);
    chk("R7 one rx_done per frame", n_done - d0, 1);
  endtask

  task automatic t_missed;
    int d0, m0;
    setdesc(2, 0, 'h1200, 64);
    fill('h1200, 4, 16'h5555);
    d0 = n_done; m0 = n_miss;
    send(6, 'h60, 0, 0);
    chk("R8 missed pulse", n_miss - m0, 1);
    chk("R8 no rx_done", n_done - d0, 0);
    chk("R8 descriptor untouched", int'(dw(2, 2)), 'h0000);
    chk("R8 buffer untouched", int'(mem[('h1200 >> 1)]), 'h5555);
    setdesc(2, 1, 'h1200, 64);
    send(4, 'h68, 0, 0);
    chk("R8 index held", int'(dw(2, 2)), 'h0300);
    chk("R8 data at held index", int'(gb('h1200)), 'h68);
  endtask

  task automatic t_overflow;
    int d0, m0;
    setdesc(3, 1, 'h1300, 8);
    setdesc(0, 0, 'h1000, 64);
    fill('h1000, 4, 16'h5555);
    d0 = n_done; m0 = n_miss;
    send(12, 'h70, 0, 0);
    chk("R9 overflow flags", int'(dw(3, 2)), 'h5600);
    chk("R9 rx_done", n_done - d0, 1);
    chk("R9 next not written", int'(dw(0, 2)), 'h0000);
    chk("R9 next buffer untouched", int'(mem[('h1000 >> 1)]), 'h5555);
    send(3, 'h80, 0, 0);
    chk("R9 index advanced then missed", n_miss - m0, 1);
    setdesc(0, 1, 'h1000, 64);
    send(2, 'h90, 0, 0);
    chk("R9 rest discarded", int'(gb('h1000)), 'h90);
    chk("R10 wrapped slot flag", int'(dw(0, 2)), 'h0300);
  endtask

  task automatic t_stray;
    int d0, m0;
    setdesc(1, 1, 'h1100, 64);
    d0 = n_done; m0 = n_miss;
    for (int k = 0; k < 3; k++) push(8'(k), 0, 0, 0, 0);
    idle_wait();
    chk("R11 no pulses", (n_done - d0) + (n_miss - m0), 0);
    chk("R11 descriptor untouched", int'(dw(1, 2)), 'h8000);
    send(2, 'hA0, 0, 0);
    chk("R11 next frame normal", int'(dw(1, 2)), 'h0300);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    tests++; fails++;
    $display("FAIL R7 watchdog: got hang expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < 4096; k++) mem[k] = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_single();
    t_odd_crc();
    t_frame_err();
    t_chain();
    t_missed();
    t_overflow();
    t_stray();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule